// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Dual Interrupt Lines

This block is one bank of 32 general-purpose pins behind a plain 32-bit register port. Software writes a direction word, an output latch and four per-pin event-detect enable words. It reads back the synchronised pin levels and the latch. The latch can be updated with single-bit precision through two alias addresses: one sets the masked bits and one clears them. A read-modify-write is not needed.

Each pin can flag an event on a low level, a high level, a rising edge or a falling edge, in any combination. Every event is recorded in two independent pending-status words, one per interrupt line. Each line has its own enable word, written through set and clear aliases. Each line drives its own interrupt output, so two consumers can take the same pin events under separate masks.

Reads use a combinational path from the offset on the address port. Writes take effect at the clock edge on which the write strobe is high. The asynchronous active-low reset is released through a two-flop stage.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction word reads 0xFFFFFFFF, the output latch reads 0, both interrupt outputs are low, both raw status words read 0, and offset 0x000 reads the constant 0x50600801.
- R2: The direction word at offset 0x134 is read/write. A 1 in bit n makes pin n an input, and `pin_oe_n[n]` follows the stored bit. A 0 makes pin n an output.
- R3: Writing a mask to 0x194 sets the masked latch bits. Writing a mask to 0x190 clears them. Zero mask bits leave the latch unchanged. The latch reads back at 0x13C and drives `pin_out`.
- R4: Offset 0x138 returns the pin levels through a two-flop synchroniser. A change driven on `pin_in` is visible after two clock edges and not after one.
- R5: When a bit is set in the low-level enable (0x140), the pin raises an event on every cycle its synchronised level is 0. The high-level enable (0x144) does the same on every cycle the level is 1.
- R6: The rising-edge enable (0x148) and the falling-edge enable (0x14C) raise one event per matching transition of the synchronised level. A steady level raises no further events.
- R7: The detect enables of a pin are OR-combined. A pin with both edge enables set flags both its rising and its falling transitions.
- R8: Raw status (line 0 at 0x24, line 1 at 0x28) records every event regardless of enables. Masked status (line 0 at 0x2C, line 1 at 0x30) reads raw status AND the line's enable.
- R9: A line's enable word is set by writing 1s to its set alias (line 0 at 0x34, line 1 at 0x38). It is cleared by writing 1s to its clear alias (line 0 at 0x3C, line 1 at 0x40). Both aliases read back the enable word.
- R10: Writing 1 to a bit of a line's masked-status address clears that pending bit. Writing 0 changes nothing. If an event for the bit arrives in the same cycle as the acknowledge, the bit stays set.
- R11: The two lines are independent. An acknowledge or an enable change on one line leaves the other line's status and enable words unchanged.
- R12: Each interrupt output is a register that goes high one clock after any bit of (raw status AND enable) of its line is set, and low one clock after none is.
- R13: Reads of unmapped offsets return 0. Writes to unmapped offsets and to read-only offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte offset for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the offset on `reg_addr` (combinational) |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output latch value |
| pin_oe_n | output | 32 | Per-pin driver disable (1 = input) |
| irq | output | 2 | Interrupt lines 0 and 1 |

## Verification
The hardest case to reach is an acknowledge that lands on the same clock edge as a fresh event for the same bit. The event is only present for one cycle, two edges after the pin moves.

The bench reaches it by scheduling the write to the masked-status address exactly two falling edges after it changes a pin that has rising-edge detect enabled. It then checks that the bit is still pending. A continuous high-level event under a repeated acknowledge covers the same priority in its steady form.

Separating raw from masked status, and one line from the other, relies on enabling a bit on only one line and acknowledging on only one line. The bench checks after each step that the other words stay as they were.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned PINS   = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NLINES = 2;

  typedef logic [PINS-1:0] word_t;

  localparam logic [31:0] REV_ID = 32'h5060_0801;

  // byte offsets decoded by software
  localparam logic [ADDR_W-1:0] A_REV      = 12'h000;
  localparam logic [ADDR_W-1:0] A_RAW0     = 12'h024;
  localparam logic [ADDR_W-1:0] A_RAW1     = 12'h028;
  localparam logic [ADDR_W-1:0] A_STS0     = 12'h02C;
  localparam logic [ADDR_W-1:0] A_STS1     = 12'h030;
  localparam logic [ADDR_W-1:0] A_ENSET0   = 12'h034;
  localparam logic [ADDR_W-1:0] A_ENSET1   = 12'h038;
  localparam logic [ADDR_W-1:0] A_ENCLR0   = 12'h03C;
  localparam logic [ADDR_W-1:0] A_ENCLR1   = 12'h040;
  localparam logic [ADDR_W-1:0] A_DIR      = 12'h134;
  localparam logic [ADDR_W-1:0] A_PINLVL   = 12'h138;
  localparam logic [ADDR_W-1:0] A_LATCH    = 12'h13C;
  localparam logic [ADDR_W-1:0] A_DLOW     = 12'h140;
  localparam logic [ADDR_W-1:0] A_DHIGH    = 12'h144;
  localparam logic [ADDR_W-1:0] A_DRISE    = 12'h148;
  localparam logic [ADDR_W-1:0] A_DFALL    = 12'h14C;
  localparam logic [ADDR_W-1:0] A_LATCLR   = 12'h190;
  localparam logic [ADDR_W-1:0] A_LATSET   = 12'h194;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] en_low,
  input  logic [W-1:0] en_high,
  input  logic [W-1:0] en_rise,
  input  logic [W-1:0] en_fall,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rose;
  logic [W-1:0] fell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  always_comb begin
    rose = level & ~prev_q;
    fell = ~level & prev_q;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_pin
      assign evt[g] = (en_low[g]  & ~level[g]) |
                      (en_high[g] &  level[g]) |
                      (en_rise[g] &  rose[g])  |
                      (en_fall[g] &  fell[g]);
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] wdata,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         ack_we,
  output logic [W-1:0] raw,
  output logic [W-1:0] en,
  output logic         irq
);
  logic [W-1:0] raw_q, raw_d;
  logic [W-1:0] en_q, en_d;
  logic         irq_q, irq_d;
  logic [W-1:0] ack_mask;

  always_comb begin
    ack_mask = ack_we ? wdata : '0;
    // an arriving event takes priority over a simultaneous acknowledge
    raw_d    = (raw_q & ~ack_mask) | evt;
    en_d     = en_q;
    if (set_we)      en_d = en_q | wdata;
    else if (clr_we) en_d = en_q & ~wdata;
    irq_d    = |(raw_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      if (set_we || clr_we) en_q <= en_d;
      irq_q <= irq_d;
    end
  end

  assign raw = raw_q;
  assign en  = en_q;
  assign irq = irq_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]   reg_wdata,
  output logic [PINS-1:0]   reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe_n,
  output logic [NLINES-1:0] irq
);
  // reset: asserted asynchronously, released after two edges
  logic rst_meta_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  // write decode
  logic we_dir, we_latch, we_lset, we_lclr;
  logic we_dlow, we_dhigh, we_drise, we_dfall;
  logic [NLINES-1:0] we_enset, we_enclr, we_ack;

  always_comb begin
    we_dir   = reg_wr && (reg_addr == A_DIR);
    we_latch = reg_wr && (reg_addr == A_LATCH);
    we_lset  = reg_wr && (reg_addr == A_LATSET);
    we_lclr  = reg_wr && (reg_addr == A_LATCLR);
    we_dlow  = reg_wr && (reg_addr == A_DLOW);
    we_dhigh = reg_wr && (reg_addr == A_DHIGH);
    we_drise = reg_wr && (reg_addr == A_DRISE);
    we_dfall = reg_wr && (reg_addr == A_DFALL);
    we_enset = {reg_wr && (reg_addr == A_ENSET1), reg_wr && (reg_addr == A_ENSET0)};
    we_enclr = {reg_wr && (reg_addr == A_ENCLR1), reg_wr && (reg_addr == A_ENCLR0)};
    we_ack   = {reg_wr && (reg_addr == A_STS1),   reg_wr && (reg_addr == A_STS0)};
  end

  // configuration registers
  word_t dir_q, dir_d;
  word_t latch_q, latch_d;
  word_t dlow_q, dhigh_q, drise_q, dfall_q;
  logic  latch_ce;

  always_comb begin
    dir_d    = reg_wdata;
    latch_ce = we_latch | we_lset | we_lclr;
    latch_d  = latch_q;
    if (we_latch)     latch_d = reg_wdata;
    else if (we_lset) latch_d = latch_q | reg_wdata;
    else if (we_lclr) latch_d = latch_q & ~reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dir_q   <= '1;
      latch_q <= '0;
      dlow_q  <= '0;
      dhigh_q <= '0;
      drise_q <= '0;
      dfall_q <= '0;
    end else begin
      if (we_dir)   dir_q   <= dir_d;
      if (latch_ce) latch_q <= latch_d;
      if (we_dlow)  dlow_q  <= reg_wdata;
      if (we_dhigh) dhigh_q <= reg_wdata;
      if (we_drise) drise_q <= reg_wdata;
      if (we_dfall) dfall_q <= reg_wdata;
    end
  end

  // input path
  word_t level;
  word_t evt;

  gpio_pin_sync #(.W(PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sn),
    .async_in (pin_in),
    .sync_out (level)
  );

  gpio_evt_detect #(.W(PINS)) u_detect (
    .clk     (clk),
    .rst_n   (rst_sn),
    .level   (level),
    .en_low  (dlow_q),
    .en_high (dhigh_q),
    .en_rise (drise_q),
    .en_fall (dfall_q),
    .evt     (evt)
  );

  // interrupt lines
  word_t [NLINES-1:0] line_raw;
  word_t [NLINES-1:0] line_en;

  genvar l;
  generate
    for (l = 0; l < NLINES; l++) begin : g_line
      gpio_irq_line #(.W(PINS)) u_line (
        .clk    (clk),
        .rst_n  (rst_sn),
        .evt    (evt),
        .wdata  (reg_wdata),
        .set_we (we_enset[l]),
        .clr_we (we_enclr[l]),
        .ack_we (we_ack[l]),
        .raw    (line_raw[l]),
        .en     (line_en[l]),
        .irq    (irq[l])
      );
    end
  endgenerate

  // read mux
  always_comb begin
    case (reg_addr)
      A_REV:              reg_rdata = REV_ID;
      A_RAW0:             reg_rdata = line_raw[0];
      A_RAW1:             reg_rdata = line_raw[1];
      A_STS0:             reg_rdata = line_raw[0] & line_en[0];
      A_STS1:             reg_rdata = line_raw[1] & line_en[1];
      A_ENSET0, A_ENCLR0: reg_rdata = line_en[0];
      A_ENSET1, A_ENCLR1: reg_rdata = line_en[1];
      A_DIR:              reg_rdata = dir_q;
      A_PINLVL:           reg_rdata = level;
      A_LATCH:            reg_rdata = latch_q;
      A_DLOW:             reg_rdata = dlow_q;
      A_DHIGH:            reg_rdata = dhigh_q;
      A_DRISE:            reg_rdata = drise_q;
      A_DFALL:            reg_rdata = dfall_q;
      default:            reg_rdata = '0;
    endcase
  end

  assign pin_out  = latch_q;
  assign pin_oe_n = dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_sn,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [PINS-1:0]   reg_wdata,
  input logic [PINS-1:0]   reg_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe_n,
  input logic [NLINES-1:0] irq,
  input word_t [NLINES-1:0] line_raw,
  input word_t [NLINES-1:0] line_en,
  input word_t             evt
);
  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    case (a)
      12'h000, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h038,
      12'h03C, 12'h040, 12'h134, 12'h138, 12'h13C, 12'h140, 12'h144,
      12'h148, 12'h14C: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // R2: the driver-disable pins move only on a direction write
  a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !(reg_wr && reg_addr == 12'h134) |=> $stable(pin_oe_n));

  // R3: set alias forces the masked latch bits high
  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wr && reg_addr == 12'h194) |=> ((pin_out & $past(reg_wdata)) == $past(reg_wdata)));

  // R3: clear alias forces the masked latch bits low
  a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wr && reg_addr == 12'h190) |=> ((pin_out & $past(reg_wdata)) == '0));

  // R9: enable set and clear aliases of line 0
  a_r9_en_set: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wr && reg_addr == 12'h034) |=> ((line_en[0] & $past(reg_wdata)) == $past(reg_wdata)));

  a_r9_en_clr: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wr && reg_addr == 12'h03C) |=> ((line_en[0] & $past(reg_wdata)) == '0));

  // R10: an event is recorded even under a simultaneous acknowledge
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_sn)
    (evt != '0) |=> ((line_raw[0] & $past(evt)) == $past(evt)));

  // R11: an acknowledge on line 1 leaves line 0 status untouched
  a_r11_line_indep: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wr && reg_addr == 12'h030) |=> ((line_raw[0] & $past(line_raw[0])) == $past(line_raw[0])));

  // R12: an interrupt needs an enabled bit one cycle earlier
  a_r12_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_sn)
    irq[0] |-> ($past(line_en[0]) != '0));

  // R13: unmapped reads return zero
  always_comb begin
    if (rst_sn && !is_mapped(reg_addr)) begin
      a_r13_unmapped_zero: assert (reg_rdata == '0);
    end
  end
endmodule

bind gpio_irq_bank gpio_irq_bank_chk u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_out   (pin_out),
  .pin_oe_n  (pin_oe_n),
  .irq       (irq),
  .line_raw  (line_raw),
  .line_en   (line_en),
  .evt       (evt)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [11:0] O_REV = 12'h000, O_RAW0 = 12'h024, O_RAW1 = 12'h028,
    O_STS0 = 12'h02C, O_STS1 = 12'h030, O_ENS0 = 12'h034, O_ENS1 = 12'h038,
    O_ENC0 = 12'h03C, O_DIR = 12'h134, O_LVL = 12'h138,
    O_LAT = 12'h13C, O_DLO = 12'h140, O_DHI = 12'h144, O_DRI = 12'h148,
    O_DFA = 12'h14C, O_LCLR = 12'h190, O_LSET = 12'h194;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe_n;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  gpio_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(O_REV, v);  check("R1 revision", v, 32'h5060_0801);
    rd(O_DIR, v);  check("R1 direction", v, 32'hFFFF_FFFF);
    rd(O_LAT, v);  check("R1 latch", v, 32'h0);
    rd(O_RAW0, v); check("R1 raw0", v, 32'h0);
    rd(O_RAW1, v); check("R1 raw1", v, 32'h0);
    check("R1 irq", {30'b0, irq}, 32'h0);
    check("R1 pin_oe_n", pin_oe_n, 32'hFFFF_FFFF);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(O_DIR, 32'h0000_FF00);
    rd(O_DIR, v); check("R2 direction readback", v, 32'h0000_FF00);
    check("R2 pin_oe_n", pin_oe_n, 32'h0000_FF00);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    wr(O_LSET, 32'hF0F0_0001);
    rd(O_LAT, v); check("R3 set alias", v, 32'hF0F0_0001);
    wr(O_LCLR, 32'h00F0_0000);
    rd(O_LAT, v); check("R3 clear alias", v, 32'hF000_0001);
    wr(O_LSET, 32'h0);
    wr(O_LCLR, 32'h0);
    rd(O_LAT, v); check("R3 zero mask unchanged", v, 32'hF000_0001);
    check("R3 pin_out", pin_out, 32'hF000_0001);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 32'h0000_00A5;
    cyc(1);
    rd(O_LVL, v); check("R4 level after one edge", v, 32'h0);
    cyc(1);
    rd(O_LVL, v); check("R4 level after two edges", v, 32'h0000_00A5);
    pin_in = 32'h0;
    cyc(4);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(O_DLO, 32'h0000_0010);        // pin 4 rests low
    cyc(2);
    rd(O_RAW0, v); check("R5 low level event", v & 32'h10, 32'h10);
    wr(O_DHI, 32'h0000_0008);
    @(negedge clk); pin_in[3] = 1'b1;
    cyc(4);
    rd(O_RAW0, v); check("R5 high level event", v & 32'h8, 32'h8);
    wr(O_STS0, 32'h0000_0008);       // pin still high: keeps re-arming
    rd(O_RAW0, v); check("R10 level event beats ack", v & 32'h8, 32'h8);
    @(negedge clk); pin_in[3] = 1'b0;
    wr(O_DLO, 32'h0); wr(O_DHI, 32'h0);
    cyc(4);
    wr(O_STS0, 32'h0000_0018);
    wr(O_STS1, 32'h0000_0018);
    rd(O_RAW0, v); check("R10 ack clears", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(O_DRI, 32'h0010_0100);        // rise on 8 and 20
    wr(O_DFA, 32'h0000_0200);        // fall on 9
    @(negedge clk); pin_in[9:8] = 2'b11;
    cyc(4);
    rd(O_RAW0, v); check("R6 rise flagged, rise of fall-only pin ignored", v, 32'h0000_0100);
    wr(O_STS0, 32'h0000_0100);
    cyc(3);
    rd(O_RAW0, v); check("R6 steady high no new event", v, 32'h0);
    @(negedge clk); pin_in[9] = 1'b0;
    cyc(4);
    rd(O_RAW0, v); check("R6 fall flagged", v, 32'h0000_0200);
    wr(O_STS0, 32'h0000_0200);
    // ack landing on the very edge that records a rising event on pin 20
    @(negedge clk); pin_in[20] = 1'b1;
    @(negedge clk);
    wr(O_STS0, 32'h0010_0000);
    rd(O_RAW0, v); check("R10 edge event beats coincident ack", v, 32'h0010_0000);
    wr(O_STS0, 32'h0010_0000);
    rd(O_RAW0, v); check("R10 later ack clears", v, 32'h0);
    wr(O_STS1, 32'hFFFF_FFFF);
  endtask

  task automatic t_or();
    logic [31:0] v;
    wr(O_DRI, 32'h0000_1000);
    wr(O_DFA, 32'h0000_1000);
    @(negedge clk); pin_in[12] = 1'b1;
    cyc(4);
    rd(O_RAW0, v); check("R7 rise with both enables", v, 32'h0000_1000);
    wr(O_STS0, 32'h0000_1000);
    @(negedge clk); pin_in[12] = 1'b0;
    cyc(4);
    rd(O_RAW0, v); check("R7 fall with both enables", v, 32'h0000_1000);
    wr(O_STS0, 32'h0000_1000);
    wr(O_STS1, 32'hFFFF_FFFF);
    wr(O_DFA, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(O_ENS0, 32'h0000_1000);
    rd(O_ENS0, v); check("R9 enable set", v, 32'h0000_1000);
    rd(O_ENS1, v); check("R11 other line enable untouched", v, 32'h0);
    check("R12 irq idle", {30'b0, irq}, 32'h0);
    @(negedge clk); pin_in[12] = 1'b1;   // rise enabled on 12
    cyc(3);
    rd(O_RAW1, v); check("R8 raw ignores enable", v, 32'h0000_1000);
    check("R12 irq not yet", {30'b0, irq}, 32'h0);
    cyc(1);
    check("R12 irq line0 only", {30'b0, irq}, 32'h1);
    rd(O_STS0, v); check("R8 masked status line0", v, 32'h0000_1000);
    rd(O_STS1, v); check("R8 masked status line1", v, 32'h0);
    wr(O_STS1, 32'h0000_1000);
    rd(O_RAW1, v); check("R11 ack line1", v, 32'h0);
    rd(O_RAW0, v); check("R11 line0 kept", v, 32'h0000_1000);
    wr(O_STS0, 32'h0);
    rd(O_RAW0, v); check("R10 write zero no effect", v, 32'h0000_1000);
    wr(O_ENC0, 32'h0000_1000);
    rd(O_ENC0, v); check("R9 enable clear", v, 32'h0);
    cyc(1);
    check("R12 irq drops", {30'b0, irq}, 32'h0);
    wr(O_STS0, 32'h0000_1000);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(12'h100, 32'hFFFF_FFFF);
    wr(O_REV, 32'h0);
    wr(O_LVL, 32'hFFFF_FFFF);
    rd(12'h100, v); check("R13 unmapped read", v, 32'h0);
    rd(O_REV, v);   check("R13 revision not writable", v, 32'h5060_0801);
    rd(O_DIR, v);   check("R13 direction untouched", v, 32'h0000_FF00);
    rd(O_LAT, v);   check("R13 latch untouched", v, 32'hF000_0001);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; pin_in = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_dir();
    t_latch();
    t_sync();
    t_level();
    t_edge();
    t_or();
    t_irq();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule